// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block sits on the host side of a passive serial configuration link and loads a bitstream into a target device. A `start` pulse begins a load attempt. The host first holds the target's reset line `config_n` low for a fixed minimum time and then releases it. It waits until the target's open-drain status line `status_n` reads high. Only then does it begin to accept bytes from a valid/ready byte stream and shift them out on `data0`, least significant bit first. The target samples `data0` on the rising edge of `dclk`, and the host changes `data0` only while `dclk` is low.

The load ends when the target's `conf_done` line rises. The host finishes the byte it is currently sending and then reports `done`. The host stops and reports `error` in two cases:

- `status_n` drops during shifting.
- `conf_done` has not risen by the time a set number of all-ones padding bytes have been sent after the byte marked last.

Both status inputs pass through two-flop synchronizers before the controller uses them.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset, `config_n` is 1, `dclk` is 0, and `done`, `error` and `in_ready` are 0.
- R2: A `start` pulse taken in idle, done or error drives `config_n` low for exactly `RST_HOLD` system clocks, after which it returns high.
- R3: Until `status_n` has read high through the two-flop synchronizer, `in_ready` stays low and no `dclk` rising edge is produced.
- R4: Each byte goes out least significant bit first. One `dclk` rising edge is produced per bit. `dclk` stays high for `CLK_DIV` system clocks. `data0` does not change while `dclk` is high.
- R5: The byte sequence 0x02, 0x1B, 0xEE, 0x01, 0xFA appears at the `dclk` rising edges as 0100_0000 1101_1000 0111_0111 1000_0000 0101_1111.
- R6: `in_ready` is high only while shifting and no byte is in progress. A byte is taken exactly when `in_valid` and `in_ready` are both high at a clock edge, and `dclk` is low whenever `in_ready` is high.
- R7: After `conf_done` rises during shifting, the host completes the byte in progress, so the total number of `dclk` pulses is a multiple of 8. It then takes no more bytes, parks `dclk` low and holds `done` high.
- R8: If `status_n` reads low during shifting, the host raises `error`, keeps `done` low, stops `dclk` at 0 with no further pulses, drops `in_ready` and leaves `config_n` high.
- R9: After the byte marked by `in_last`, the host sends `TAIL_BYTES` padding bytes of 0xFF. If `conf_done` has not risen when they are complete, the host raises `error`.
- R10: A `start` pulse during an attempt in progress is ignored. A `start` pulse from done or error clears the flag that was set and begins a new reset phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load attempt |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Host takes the byte on this edge if `in_valid` is high |
| config_n | output | 1 | Target reset/start line, low means reset |
| dclk | output | 1 | Serial clock to the target |
| data0 | output | 1 | Serial data to the target |
| status_n | input | 1 | Target status, high means ready (open drain) |
| conf_done | input | 1 | Target completion line (open drain) |
| done | output | 1 | Load completed |
| error | output | 1 | Load aborted |

## Verification
A controller that enters shifting without a valid ready status shows up at once as `dclk` rising edges while `status_n` is still low. A reset phase that is too short or too long shows up as a wrong `config_n` low time at the first release. A wrong bit pointer or a wrong shift direction corrupts the bit sequence captured at the `dclk` rising edges within the first byte. A missed completion or fault event shows up within one byte time as an extra non-multiple-of-8 pulse count, continued pulses after a fault, or a `done`/`error` flag that does not match the stimulus.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE,
    ST_ERROR
  } cfg_state_e;

  localparam logic [7:0] PAD_BYTE = 8'hFF;

  // Next shift register value once the current low bit has been sent.
  function automatic logic [7:0] lsb_advance(input logic [7:0] b);
    return {1'b0, b[7:1]};
  endfunction

  // True on the last system clock of a half period of dclk.
  function automatic logic div_due(input logic [31:0] cnt, input logic [31:0] div);
    return cnt == (div - 32'd1);
  endfunction

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
      end
    end
    assign sync_out[i] = sync_q;
  end

endmodule

// File: rtl/ps_cfg_divider.sv
module ps_cfg_divider
  import ps_cfg_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && div_due(32'(cnt), 32'(DIV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  if (DIV > 1) begin : g_gap_chk
    // R4: half periods never collapse to one system clock
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter
  import ps_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  output logic       busy,
  output logic       byte_end,
  output logic       dclk,
  output logic       data0
);

  logic [7:0] sh_q;
  logic [2:0] bit_q;
  logic       have_q;
  logic       dclk_q;

  assign busy     = have_q;
  assign dclk     = dclk_q;
  assign data0    = have_q & sh_q[0];
  assign byte_end = have_q && tick && dclk_q && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      have_q <= 1'b0;
      dclk_q <= 1'b0;
    end else if (!run) begin
      have_q <= 1'b0;
      dclk_q <= 1'b0;
      bit_q  <= '0;
    end else if (load && !have_q) begin
      sh_q   <= load_byte;
      bit_q  <= '0;
      have_q <= 1'b1;
    end else if (have_q && tick) begin
      if (!dclk_q) begin
        dclk_q <= 1'b1;
      end else begin
        dclk_q <= 1'b0;
        sh_q   <= lsb_advance(sh_q);
        bit_q  <= bit_q + 3'd1;
        if (bit_q == 3'd7) have_q <= 1'b0;
      end
    end
  end

  // R4: the target's sampling edge sees a settled data line
  p_data_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(data0));

endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int RST_HOLD   = 8,
  parameter int TAIL_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       config_n,
  output logic       dclk,
  output logic       data0,
  input  logic       status_n,
  input  logic       conf_done,
  output logic       done,
  output logic       error
);

  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam int TW = $clog2(TAIL_BYTES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);
  localparam logic [TW-1:0] TAIL_MAX  = TW'(TAIL_BYTES);

  cfg_state_e state_q;
  logic [HW-1:0] hold_q;
  logic [TW-1:0] tail_cnt_q;
  logic tail_q, fin_q, conf_q;

  // named internal events
  logic [1:0] sync_vec;
  logic status_ok, conf_s, conf_rise, fin_any;
  logic sh_busy, byte_end, tick, load_req, tail_exhausted, accept, shifting;
  logic [7:0] load_byte;

  ps_cfg_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({conf_done, status_n}),
    .sync_out(sync_vec)
  );
  assign status_ok = sync_vec[0];
  assign conf_s    = sync_vec[1];
  assign conf_rise = conf_s && !conf_q;

  assign shifting       = (state_q == ST_SHIFT);
  assign fin_any        = fin_q || conf_rise;
  assign tail_exhausted = (tail_cnt_q == TAIL_MAX);
  assign in_ready       = shifting && status_ok && !sh_busy && !tail_q && !fin_any;
  assign accept         = in_ready && in_valid;
  assign load_req       = shifting && status_ok && !sh_busy && !fin_any &&
                          (tail_q ? !tail_exhausted : in_valid);
  assign load_byte      = tail_q ? PAD_BYTE : in_data;

  ps_cfg_divider #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(sh_busy), .tick(tick)
  );

  ps_cfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .run(shifting && status_ok),
    .load(load_req), .load_byte(load_byte), .tick(tick),
    .busy(sh_busy), .byte_end(byte_end),
    .dclk(dclk), .data0(data0)
  );

  assign config_n = (state_q != ST_RESET);
  assign done     = (state_q == ST_DONE);
  assign error    = (state_q == ST_ERROR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conf_q <= 1'b0;
    else        conf_q <= conf_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hold_q     <= '0;
      tail_cnt_q <= '0;
      tail_q     <= 1'b0;
      fin_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE, ST_ERROR: begin
          if (start) begin
            state_q    <= ST_RESET;
            hold_q     <= '0;
            tail_cnt_q <= '0;
            tail_q     <= 1'b0;
            fin_q      <= 1'b0;
          end
        end
        ST_RESET: begin
          if (hold_q == HOLD_LAST) state_q <= ST_WAIT;
          else                     hold_q  <= hold_q + 1'b1;
        end
        ST_WAIT: begin
          if (status_ok) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (conf_rise)             fin_q      <= 1'b1;
          if (accept && in_last)     tail_q     <= 1'b1;
          if (load_req && tail_q)    tail_cnt_q <= tail_cnt_q + 1'b1;
          if (!status_ok)                               state_q <= ST_ERROR;
          else if (fin_any && !sh_busy)                 state_q <= ST_DONE;
          else if (tail_q && tail_exhausted && !sh_busy) state_q <= ST_ERROR;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: bytes are only requested once the target reads as ready
  p_ready_needs_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> status_ok);
  // R6: a new byte is only offered with the serial clock parked low
  p_ready_clock_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !dclk);
  // R7: once complete the link is quiet
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dclk && !in_ready));
  // R7: completion arrives only on a byte boundary
  p_done_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(sh_busy));
  // R8: outcome flags never coexist
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R8: a dropped status during shifting aborts on the next edge
  p_fault_to_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !status_ok) |=> error);
  // R10: a start request mid-load does not restart the reset phase
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && start) |=> config_n);

endmodule

// File: tb/ps_cfg_host_bench.sv
module ps_cfg_host_bench;

  localparam int CLK_DIV    = 2;
  localparam int RST_HOLD   = 8;
  localparam int TAIL_BYTES = 3;
  localparam int STATUS_DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, config_n, dclk, data0, done, error;
  logic status_n = 1'b0, conf_done = 1'b0;

  always #4 clk = ~clk;

  ps_cfg_host #(.CLK_DIV(CLK_DIV), .RST_HOLD(RST_HOLD), .TAIL_BYTES(TAIL_BYTES)) u_ps_cfg_host (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .config_n(config_n), .dclk(dclk), .data0(data0),
    .status_n(status_n), .conf_done(conf_done),
    .done(done), .error(error)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] buf_b [0:15];
  logic bits [0:511];
  int nbits = 0, rise_low = 0;
  int low_run = 0, last_low = 0, releases = 0;
  int hi_run = 0, per_err = 0, stab_err = 0;
  int stat_hi = 0, ready_early = 0, accepted = 0;
  int st_dly = 0, conf_at = 0;
  bit kill = 1'b0;
  logic prev_dclk = 1'b0, prev_data = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // target capture at the sampling edge
  always @(posedge dclk) begin
    if (nbits < 512) bits[nbits] = data0;
    nbits++;
    if (!status_n) rise_low++;
  end

  // monitors first, then the target model
  always @(negedge clk) begin
    if (!config_n) low_run++;
    else if (low_run > 0) begin last_low = low_run; low_run = 0; releases++; end
    if (prev_dclk && dclk && (data0 != prev_data)) stab_err++;
    if (dclk) hi_run++;
    else if (hi_run > 0) begin if (hi_run != CLK_DIV) per_err++; hi_run = 0; end
    prev_dclk = dclk; prev_data = data0;
    if (status_n) stat_hi++; else stat_hi = 0;
    if (in_ready && stat_hi < 2) ready_early++;
    if (in_ready && in_valid) accepted++;
    if (!config_n) begin
      status_n = 1'b0; conf_done = 1'b0; st_dly = 0;
    end else if (kill) begin
      status_n = 1'b0;
    end else if (st_dly < STATUS_DLY) st_dly++;
    else status_n = 1'b1;
    if (conf_at > 0 && nbits >= conf_at) conf_done = 1'b1;
  end

  task automatic prep(input int at);
    nbits = 0; rise_low = 0; per_err = 0; stab_err = 0;
    ready_early = 0; accepted = 0; conf_at = at;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send(input int n, input bit last, input int gap);
    for (int i = 0; i < n; i++) begin
      bit r;
      int g;
      in_data = buf_b[i]; in_valid = 1'b1; in_last = last && (i == n - 1);
      g = 0;
      forever begin
        r = in_ready;
        @(negedge clk);
        g++;
        if (r || done || error || g > 5000) break;
      end
      in_valid = 1'b0; in_last = 1'b0;
      if (done || error) break;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      if (done || error) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(config_n == 1'b1, "R1 config_n", config_n, 1);
    chk(dclk == 1'b0, "R1 dclk", dclk, 0);
    chk(done == 1'b0 && error == 1'b0, "R1 flags", {done, error}, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
  endtask

  task automatic t_example();
    logic [39:0] pat;
    int bad;
    pat = 40'b0100000011011000011101111000000001011111;
    buf_b[0] = 8'h02; buf_b[1] = 8'h1B; buf_b[2] = 8'hEE; buf_b[3] = 8'h01; buf_b[4] = 8'hFA;
    prep(40);
    pulse_start();
    send(5, 1'b1, 0);
    wait_end();
    chk(last_low == RST_HOLD, "R2 config_n low time", last_low, RST_HOLD);
    chk(rise_low == 0, "R3 dclk before ready", rise_low, 0);
    chk(ready_early == 0, "R3 in_ready before ready", ready_early, 0);
    bad = 0;
    for (int k = 0; k < 40; k++) if (bits[k] !== pat[39 - k]) bad++;
    chk(bad == 0 && nbits >= 40, "R5 example bit order", bad, 0);
    chk(stab_err == 0, "R4 data stable while dclk high", stab_err, 0);
    chk(per_err == 0, "R4 dclk high time", per_err, 0);
    chk(done == 1'b1, "R7 done after conf_done", done, 1);
    chk(nbits % 8 == 0, "R7 whole bytes", nbits, (nbits / 8) * 8);
  endtask

  task automatic t_gaps();
    int bad;
    buf_b[0] = 8'hA5; buf_b[1] = 8'h3C; buf_b[2] = 8'h81; buf_b[3] = 8'h7E;
    buf_b[4] = 8'h55; buf_b[5] = 8'h0F; buf_b[6] = 8'hC3; buf_b[7] = 8'h99;
    prep(20);
    pulse_start();
    send(8, 1'b0, 3);
    wait_end();
    chk(done == 1'b1, "R7 done", done, 1);
    chk(nbits % 8 == 0 && nbits >= 24 && nbits <= 32, "R7 pulse count", nbits, 24);
    chk(accepted * 8 == nbits, "R6 bytes taken vs sent", accepted * 8, nbits);
    bad = 0;
    for (int k = 0; k < nbits && k < 64; k++) if (bits[k] !== buf_b[k / 8][k % 8]) bad++;
    chk(bad == 0, "R4 lsb first", bad, 0);
    chk(in_ready == 1'b0 && dclk == 1'b0, "R7 quiet after done", {in_ready, dclk}, 0);
  endtask

  task automatic t_fault();
    int rel0, snap, g;
    for (int i = 0; i < 6; i++) buf_b[i] = 8'(8'h11 * (i + 1));
    prep(0);
    pulse_start();
    chk(done == 1'b0, "R10 restart clears done", done, 0);
    fork
      send(6, 1'b0, 0);
      begin
        g = 0;
        while (nbits < 12 && g < 5000) begin @(negedge clk); g++; end
        rel0 = releases; snap = nbits;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(releases == rel0 && config_n == 1'b1 && low_run == 0,
            "R10 start ignored mid-load", releases, rel0);
        chk(nbits > snap, "R10 shifting continues", nbits, snap + 1);
        kill = 1'b1;
      end
    join
    wait_end();
    chk(error == 1'b1 && done == 1'b0, "R8 error flag", {done, error}, 1);
    chk(dclk == 1'b0 && in_ready == 1'b0 && config_n == 1'b1, "R8 outputs parked",
        {dclk, in_ready, config_n}, 1);
    snap = nbits;
    repeat (50) @(negedge clk);
    chk(nbits == snap, "R8 no pulses after fault", nbits, snap);
  endtask

  task automatic t_tail();
    int bad;
    kill = 1'b0;
    buf_b[0] = 8'h81; buf_b[1] = 8'h42;
    prep(0);
    pulse_start();
    chk(error == 1'b0, "R10 restart clears error", error, 0);
    send(2, 1'b1, 0);
    wait_end();
    chk(error == 1'b1 && done == 1'b0, "R9 timeout error", {done, error}, 1);
    chk(nbits == 16 + 8 * TAIL_BYTES, "R9 padding length", nbits, 16 + 8 * TAIL_BYTES);
    bad = 0;
    for (int k = 16; k < nbits && k < 64; k++) if (bits[k] !== 1'b1) bad++;
    chk(bad == 0, "R9 padding all ones", bad, 0);
    bad = 0;
    for (int k = 0; k < 16; k++) if (bits[k] !== buf_b[k / 8][k % 8]) bad++;
    chk(bad == 0, "R4 data before padding", bad, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_gaps();
    t_fault();
    t_tail();
    finish_run();
  end

endmodule